// File: doc/BRIEF.md
# PCM Playback Sample Unpacker

This block turns a byte stream of packed PCM audio into one signed 16-bit left/right pair per sample period. A 32-byte playback FIFO is loaded one 32-bit little-endian word at a time. A programmable clock divider produces the sample tick; in a system it is set so that the tick runs at 48 kHz. On each tick the unpacker reads a 2-bit format code. It takes the number of bytes that format needs from the head of the FIFO and presents the decoded pair with a one-cycle valid strobe.

Four formats are supported: mono or stereo, each with either unsigned 8-bit or signed 16-bit samples. Unsigned 8-bit data is widened to signed 16 bits by inverting its top bit and placing it in the upper byte. Mono formats copy the single sample to both channels. If the FIFO holds fewer bytes than the selected format needs when a tick arrives, nothing is consumed and the pair is silence (both zero).

Top module: `pcm_fifo_unpacker`

## Requirements
- R1: The sample tick fires once every `tick_div + 1` clock cycles; the pair and its strobe appear in the cycle after the tick.
- R2: `sample_valid` is high for exactly one cycle per tick and never without a preceding tick.
- R3: Format code 2'b00 (mono, 8-bit) consumes 1 byte `b` and drives `{b ^ 8'h80, 8'h00}` on both left and right.
- R4: Format code 2'b01 (stereo, 8-bit) consumes 2 bytes; the first byte gives left and the second gives right, each widened as in R3.
- R5: Format code 2'b10 (mono, 16-bit) consumes 2 bytes read little-endian (first byte is bits 7:0) and drives that value on both channels.
- R6: Format code 2'b11 (stereo, 16-bit) consumes 4 bytes: the first two little-endian bytes are left and the next two are right.
- R7: When the FIFO level is below the byte count the format needs, the tick consumes nothing (level unchanged) and both outputs are zero with the strobe still pulsed.
- R8: `fifo_level` equals bytes pushed minus bytes consumed and never exceeds 32; a push while fewer than 4 bytes are free is discarded. A pushed word stores its bits 7:0 first.
- R9: Byte order is preserved when the FIFO's storage index wraps from its last entry back to the first.
- R10: After reset the FIFO is empty, both samples are zero and `sample_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_div | input | 16 | Tick period minus one, in clock cycles |
| fmt_sel | input | 2 | Sample format code, sampled on each tick |
| push_en | input | 1 | Write one 4-byte word into the FIFO |
| push_word | input | 32 | Word to write, least significant byte first |
| fifo_level | output | 6 | Bytes currently held in the FIFO |
| sample_left | output | 16 | Left sample |
| sample_right | output | 16 | Right sample |
| sample_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
The hardest states to reach are a completely full FIFO and a refused push. Ticks drain bytes constantly, so the bench writes nine words back to back inside one tick gap. It then drains the eight that were accepted; by that point the indices have wrapped, and the refused word must never show up. A partial-level underrun is reached by changing the format between ticks, so that two leftover bytes fall short of a 4-byte format and are then consumed by a 2-byte one.

// File: rtl/pcm_unpack_pkg.sv
package pcm_unpack_pkg;

  typedef enum logic [1:0] {
    FMT_MONO8    = 2'b00,
    FMT_STEREO8  = 2'b01,
    FMT_MONO16   = 2'b10,
    FMT_STEREO16 = 2'b11
  } pcm_fmt_e;

  typedef struct packed {
    logic [15:0] left;
    logic [15:0] right;
  } stereo_pair_t;

  // Bytes a format consumes per sample period.
  function automatic logic [2:0] fmt_bytes(pcm_fmt_e f);
    case (f)
      FMT_MONO8:    return 3'd1;
      FMT_STEREO8:  return 3'd2;
      FMT_MONO16:   return 3'd2;
      default:      return 3'd4;
    endcase
  endfunction

  // Unsigned 8-bit to signed 16-bit.
  function automatic logic [15:0] widen_u8(logic [7:0] b);
    return {b ^ 8'h80, 8'h00};
  endfunction

  // Decode the four head bytes (byte 0 in bits 7:0) for a format.
  function automatic stereo_pair_t unpack_head(pcm_fmt_e f, logic [31:0] head);
    stereo_pair_t p;
    case (f)
      FMT_MONO8: begin
        p.left  = widen_u8(head[7:0]);
        p.right = p.left;
      end
      FMT_STEREO8: begin
        p.left  = widen_u8(head[7:0]);
        p.right = widen_u8(head[15:8]);
      end
      FMT_MONO16: begin
        p.left  = head[15:0];
        p.right = head[15:0];
      end
      default: begin
        p.left  = head[15:0];
        p.right = head[31:16];
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pcm_tick_div.sv
module pcm_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_value,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  // ">=" keeps the divider live if the limit shrinks below the count.
  assign tick = (cnt >= div_value);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tick == (div_value == '0)));

endmodule

// File: rtl/pcm_byte_fifo.sv
module pcm_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LVL_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_en,
  input  logic [8*LANES-1:0] push_word,
  input  logic               pop_en,
  input  logic [2:0]         pop_cnt,
  output logic [8*LANES-1:0] head_word,
  output logic [LVL_W-1:0]   level
);

  logic [7:0]       mem [DEPTH];
  logic [LVL_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] room;
  logic             push_ok;

  assign level   = wr_ptr - rd_ptr;
  assign room    = LVL_W'(DEPTH) - level;
  assign push_ok = push_en && (room >= LVL_W'(LANES));

  always_ff @(posedge clk) begin
    if (push_ok) begin
      for (int i = 0; i < LANES; i++)
        mem[IDX_W'(wr_ptr[IDX_W-1:0] + IDX_W'(i))] <= push_word[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + LVL_W'(LANES);
      if (pop_en)  rd_ptr <= rd_ptr + LVL_W'(pop_cnt);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign head_word[8*g +: 8] = mem[IDX_W'(rd_ptr[IDX_W-1:0] + IDX_W'(g))];
  end

  // R7
  pop_within_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (level >= LVL_W'(pop_cnt)));
  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  // R8
  push_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && (room < LVL_W'(LANES)) && !pop_en) |=> (level == $past(level)));

endmodule

// File: rtl/pcm_frame_decode.sv
module pcm_frame_decode
  import pcm_unpack_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       fmt_sel,
  input  logic [LVL_W-1:0] level,
  input  logic [31:0]      head_word,
  output logic             pop_en,
  output logic [2:0]       pop_cnt,
  output logic [15:0]      sample_left,
  output logic [15:0]      sample_right,
  output logic             sample_valid
);

  pcm_fmt_e     fmt;
  logic         enough;
  stereo_pair_t pair;
  logic [1:0]   fmt_q;

  assign fmt     = pcm_fmt_e'(fmt_sel);
  assign pop_cnt = fmt_bytes(fmt);
  assign enough  = (level >= LVL_W'(pop_cnt));
  assign pop_en  = tick && enough;
  assign pair    = unpack_head(fmt, head_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_left  <= '0;
      sample_right <= '0;
      sample_valid <= 1'b0;
      fmt_q        <= '0;
    end else begin
      sample_valid <= tick;
      if (tick) begin
        fmt_q        <= fmt_sel;
        sample_left  <= enough ? pair.left  : 16'h0000;
        sample_right <= enough ? pair.right : 16'h0000;
      end
    end
  end

  // R7
  underrun_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !enough) |=> (sample_valid && sample_left == 16'h0 && sample_right == 16'h0));
  // R3
  mono_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !fmt_q[0]) |-> (sample_left == sample_right));

endmodule

// File: rtl/pcm_fifo_unpacker.sv
module pcm_fifo_unpacker #(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DIV_W-1:0]            tick_div,
  input  logic [1:0]                  fmt_sel,
  input  logic                        push_en,
  input  logic [31:0]                 push_word,
  output logic [$clog2(FIFO_DEPTH):0] fifo_level,
  output logic [15:0]                 sample_left,
  output logic [15:0]                 sample_right,
  output logic                        sample_valid
);

  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  logic        tick_w;
  logic        pop_w;
  logic [2:0]  pop_cnt_w;
  logic [31:0] head_w;

  pcm_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_value (tick_div),
    .tick      (tick_w)
  );

  pcm_byte_fifo #(.DEPTH(FIFO_DEPTH), .LANES(4)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_word (push_word),
    .pop_en    (pop_w),
    .pop_cnt   (pop_cnt_w),
    .head_word (head_w),
    .level     (fifo_level)
  );

  pcm_frame_decode #(.LVL_W(LVL_W)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick_w),
    .fmt_sel      (fmt_sel),
    .level        (fifo_level),
    .head_word    (head_w),
    .pop_en       (pop_w),
    .pop_cnt      (pop_cnt_w),
    .sample_left  (sample_left),
    .sample_right (sample_right),
    .sample_valid (sample_valid)
  );

  // R2
  valid_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(tick_w));

endmodule

// File: tb/pcm_fifo_unpacker_test.sv
module pcm_fifo_unpacker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tick_div = 16'd19;
  logic [1:0]  fmt_sel = 2'b00;
  logic        push_en = 1'b0;
  logic [31:0] push_word = '0;
  logic [5:0]  fifo_level;
  logic [15:0] sample_left, sample_right;
  logic        sample_valid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pcm_fifo_unpacker uut (
    .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .fmt_sel(fmt_sel),
    .push_en(push_en), .push_word(push_word), .fifo_level(fifo_level),
    .sample_left(sample_left), .sample_right(sample_right),
    .sample_valid(sample_valid)
  );

  function automatic logic [15:0] u8_to_s16(logic [7:0] b);
    return {~b[7], b[6:0], 8'h00};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sample_valid && n < 200);
    if (!sample_valid) check("R2 strobe timeout", 0, 1);
  endtask

  task automatic push_words(input logic [31:0] w[$]);
    foreach (w[i]) begin
      push_en   = 1'b1;
      push_word = w[i];
      @(negedge clk);
    end
    push_en = 1'b0;
  endtask

  task automatic expect_pair(string req, logic [15:0] l, logic [15:0] r, logic [5:0] lvl);
    wait_valid();
    check({req, " left"},  32'(sample_left),  32'(l));
    check({req, " right"}, 32'(sample_right), 32'(r));
    check({req, " level"}, 32'(fifo_level),   32'(lvl));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 level", 32'(fifo_level), 0);
    check("R10 left", 32'(sample_left), 0);
    check("R10 right", 32'(sample_right), 0);
    check("R10 valid", 32'(sample_valid), 0);
  endtask

  task automatic t_period();
    int n;
    wait_valid();
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_valid && n < 200);
    check("R1 period div19", n, 20);
    @(negedge clk);
    check("R2 strobe one cycle", 32'(sample_valid), 0);
    tick_div = 16'd4;
    wait_valid();
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_valid && n < 200);
    check("R1 period div4", n, 5);
    tick_div = 16'd19;
    wait_valid();
    wait_valid();
  endtask

  task automatic t_underrun_empty();
    fmt_sel = 2'b11;
    expect_pair("R7 empty", 16'h0, 16'h0, 6'd0);
  endtask

  task automatic t_mono8();
    fmt_sel = 2'b00;
    push_words('{32'h0403FF00});
    expect_pair("R3 b0", u8_to_s16(8'h00), u8_to_s16(8'h00), 6'd3);
    expect_pair("R3 b1", u8_to_s16(8'hFF), u8_to_s16(8'hFF), 6'd2);
    expect_pair("R3 b2", u8_to_s16(8'h03), u8_to_s16(8'h03), 6'd1);
    expect_pair("R3 b3", u8_to_s16(8'h04), u8_to_s16(8'h04), 6'd0);
  endtask

  task automatic t_stereo8();
    fmt_sel = 2'b01;
    push_words('{32'hC0407F81});
    expect_pair("R4 first", u8_to_s16(8'h81), u8_to_s16(8'h7F), 6'd2);
    expect_pair("R4 second", u8_to_s16(8'h40), u8_to_s16(8'hC0), 6'd0);
  endtask

  task automatic t_mono16();
    fmt_sel = 2'b10;
    push_words('{32'hBEEF1234});
    expect_pair("R5 first", 16'h1234, 16'h1234, 6'd2);
    expect_pair("R5 second", 16'hBEEF, 16'hBEEF, 6'd0);
  endtask

  task automatic t_stereo16();
    fmt_sel = 2'b11;
    push_words('{32'h80007FFF});
    expect_pair("R6 pair", 16'h7FFF, 16'h8000, 6'd0);
  endtask

  task automatic t_partial();
    fmt_sel = 2'b10;
    push_words('{32'h56781234});
    expect_pair("R5 partial", 16'h1234, 16'h1234, 6'd2);
    fmt_sel = 2'b11;
    expect_pair("R7 short", 16'h0, 16'h0, 6'd2);
    fmt_sel = 2'b01;
    expect_pair("R4 leftover", u8_to_s16(8'h78), u8_to_s16(8'h56), 6'd0);
  endtask

  task automatic t_full_wrap();
    logic [31:0] w[$];
    fmt_sel = 2'b11;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] l = 16'h0011 + 16'(i) * 16'h0100;
      w.push_back({~l, l});
    end
    w.push_back(32'hDEADDEAD);
    push_words(w);
    check("R8 full level", 32'(fifo_level), 32);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] l = 16'h0011 + 16'(i) * 16'h0100;
      expect_pair("R9 drain", l, ~l, 6'(28 - 4 * i));
    end
    expect_pair("R8 refused word absent", 16'h0, 16'h0, 6'd0);
  endtask

  initial begin
    #(200000 * 4);
    check("watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_period();
    t_underrun_empty();
    t_mono8();
    t_stereo8();
    t_mono16();
    t_stereo16();
    t_partial();
    t_full_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule